// File: doc/BRIEF.md
# Key-Unlocked Trap Table Base Register

This block holds the 32-bit base address of the exception vector table and hands that address to the exception logic on a dedicated output. Stray software writes must not move the table, so the register is guarded by a separate key register. The key register takes an 8-bit value, and writing the one accepted key code opens the base register for writes. Any other key value closes it again. The base register also closes itself on any write that reaches its top byte, so a finished update leaves it protected without a separate step.

Software talks to the block over a simple register bus. Each access is a single-cycle write strobe with a register index, four byte-lane enables and 32 bits of write data. Read data is combinational from the index. The bus has no handshake: every strobed write completes in the cycle it is presented. Byte, half-word and word writes all work. Because a write to the top byte relocks the register, a half-word update has to write the lower half first and the upper half second. A word write changes all lanes in one access and then relocks. Address bits 9:0 and 31:28 are wired to zero, so the table always starts on a 1 KB boundary in the low 256 MB.

Top module: `trapbase_guard`

## Requirements
- R1: A write to index 0 with lane 0 enabled and data bits 7:0 equal to 0x59 unlocks the base register, and index 0 then reads 0x00000059.
- R2: A write to index 0 with lane 0 enabled and any other value in bits 7:0 locks the base register, and index 0 then reads 0x00000000. A write to index 0 with lane 0 disabled changes nothing.
- R3: While the register is locked, writes to index 1 leave the base value unchanged, whatever their lanes or data.
- R4: While the register is unlocked, a write to index 1 updates each byte lane whose enable bit is set (lane n is bits 8n+7:8n) and holds every other lane.
- R5: A write to index 1 with lane 3 enabled first commits all enabled lanes and then locks the register, so the next access finds it protected.
- R6: Base bits 9:0 and 31:28 always read as zero and ignore written data.
- R7: After reset the base register holds 0x00C00000 and the register is locked, so index 0 reads 0x00000000.
- R8: `base_addr_o` always equals the value read at index 1, and reads of indices 2 and 3 return zero.
- R9: Unlock, a lower half-word write and then an upper half-word write update the whole base. The reverse order updates only the upper half and drops the lower one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_idx | input | 2 | Register index: 0 key, 1 base, 2 and 3 unused |
| bus_be | input | 4 | Byte-lane enables, bit n for bits 8n+7:8n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_idx |
| base_addr_o | output | 32 | Current trap table base address |

## Verification
The bench tries every byte-lane pattern against several data patterns, once while locked and once just after an unlock. A design that leaked locked writes, or that wrote lanes whose enable was off, would show a changed base value. A design that relocked before committing the top-lane write would lose the top byte of a word write. A design that never relocked would accept the next stray write. The bench also runs the two half-word orders: wrong ordering must leave the lower half untouched. It checks that a key write without lane 0 is ignored, which catches a decoder that matches the key on any lane.

// File: rtl/trapbase_pkg.sv
package trapbase_pkg;
  localparam int IDX_W      = 2;
  localparam int KEY_W      = 8;
  localparam logic [IDX_W-1:0] IDX_KEY  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_BASE = 2'd1;
endpackage

// File: rtl/tbg_key_gate.sv
module tbg_key_gate #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_VAL = 8'h59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             relock,
  output logic             open_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      open_o <= 1'b0;
    else if (key_wr) open_o <= (key_data == KEY_VAL);
    else if (relock) open_o <= 1'b0;
  end
endmodule

// File: rtl/tbg_base_store.sv
module tbg_base_store #(
  parameter int DATA_W = 32,
  parameter int LOW_ZERO = 10,
  parameter int HIGH_ZERO = 4,
  parameter logic [DATA_W-1:0] RST_BASE = 32'h00C0_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_go,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   base_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] LIVE_MASK =
    ((DATA_W)'(1) << (DATA_W - HIGH_ZERO)) - ((DATA_W)'(1) << LOW_ZERO);
  localparam logic [DATA_W-1:0] RST_MASKED = RST_BASE & LIVE_MASK;

  logic [DATA_W-1:0] q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[g*8 +: 8] <= RST_MASKED[g*8 +: 8];
      else if (wr_go && be[g])
        q[g*8 +: 8] <= wdata[g*8 +: 8] & LIVE_MASK[g*8 +: 8];
    end
  end

  assign base_o = q & LIVE_MASK;
endmodule

// File: rtl/tbg_read_mux.sv
module tbg_read_mux #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 2,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_VAL = 8'h59
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              open_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [DATA_W-1:0] rdata
);
  import trapbase_pkg::*;
  always_comb begin
    rdata = '0;
    if (idx == IDX_KEY)
      rdata[KEY_W-1:0] = open_i ? KEY_VAL : '0;
    else if (idx == IDX_BASE)
      rdata = base_i;
  end
endmodule

// File: rtl/trapbase_guard.sv
module trapbase_guard #(
  parameter int DATA_W = 32,
  parameter int LOW_ZERO = 10,
  parameter int HIGH_ZERO = 4,
  parameter logic [7:0] KEY_VAL = 8'h59,
  parameter logic [31:0] RST_BASE = 32'h00C0_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [trapbase_pkg::IDX_W-1:0] bus_idx,
  input  logic [DATA_W/8-1:0]           bus_be,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [DATA_W-1:0]             base_addr_o
);
  import trapbase_pkg::*;
  localparam int LANES = DATA_W / 8;

  logic key_open;
  logic key_wr;
  logic base_wr;
  logic top_hit;

  assign key_wr  = bus_we && (bus_idx == IDX_KEY) && bus_be[0];
  assign base_wr = bus_we && (bus_idx == IDX_BASE);
  assign top_hit = base_wr && bus_be[LANES-1];

  tbg_key_gate #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_data(bus_wdata[KEY_W-1:0]), .relock(top_hit), .open_o(key_open)
  );

  tbg_base_store #(.DATA_W(DATA_W), .LOW_ZERO(LOW_ZERO),
                   .HIGH_ZERO(HIGH_ZERO), .RST_BASE(RST_BASE[DATA_W-1:0])) u_base (
    .clk(clk), .rst_n(rst_n), .wr_go(base_wr && key_open),
    .be(bus_be), .wdata(bus_wdata), .base_o(base_addr_o)
  );

  tbg_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .KEY_W(KEY_W),
                 .KEY_VAL(KEY_VAL)) u_rd (
    .idx(bus_idx), .open_i(key_open), .base_i(base_addr_o), .rdata(bus_rdata)
  );
endmodule

// File: rtl/tbg_checker.sv
module tbg_checker #(
  parameter int DATA_W = 32,
  parameter int LOW_ZERO = 10,
  parameter int HIGH_ZERO = 4,
  parameter logic [7:0] KEY_VAL = 8'h59
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [1:0]           bus_idx,
  input logic [DATA_W/8-1:0]  bus_be,
  input logic [7:0]           key_byte,
  input logic [DATA_W-1:0]    base_addr_o,
  input logic                 key_open
);
  localparam logic [DATA_W-1:0] LIVE_MASK =
    ((DATA_W)'(1) << (DATA_W - HIGH_ZERO)) - ((DATA_W)'(1) << LOW_ZERO);

  p_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_idx == 2'd0 && bus_be[0] && key_byte == KEY_VAL) |=> key_open);

  p_badkey_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_idx == 2'd0 && bus_be[0] && key_byte != KEY_VAL) |=> !key_open);

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_open |=> $stable(base_addr_o));

  p_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_idx == 2'd1 && !bus_be[0]) |=> $stable(base_addr_o[7:0]));

  p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_idx == 2'd1 && bus_be[DATA_W/8-1]) |=> !key_open);

  p_zero_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (base_addr_o & ~LIVE_MASK) == '0);
endmodule

bind trapbase_guard tbg_checker #(.DATA_W(DATA_W), .LOW_ZERO(LOW_ZERO),
                                  .HIGH_ZERO(HIGH_ZERO), .KEY_VAL(KEY_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_idx(bus_idx), .bus_be(bus_be),
  .key_byte(bus_wdata[7:0]), .base_addr_o(base_addr_o), .key_open(key_open)
);

// File: tb/tb_trapbase_guard.sv
module tb_trapbase_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_idx = 2'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [31:0] base_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] MASK = 32'h0FFF_FC00;
  logic [31:0] exp_base;
  bit          exp_open;

  always #10 clk = ~clk;

  trapbase_guard dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .base_addr_o(base_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_idx = idx; bus_be = be; bus_wdata = d;
    if (idx == 2'd0 && be[0]) exp_open = (d[7:0] == 8'h59);
    else if (idx == 2'd1) begin
      if (exp_open)
        for (int l = 0; l < 4; l++)
          if (be[l]) exp_base[l*8 +: 8] = d[l*8 +: 8] & MASK[l*8 +: 8];
      if (be[3]) exp_open = 1'b0;
    end
    @(negedge clk);
    bus_we = 1'b0; bus_be = 4'd0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v);
    bus_idx = idx;
    #1 v = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    rd(2'd1, v);
    chk(tag, v, exp_base);
    chk({tag, "/R8 out"}, base_addr_o, exp_base);
    rd(2'd0, v);
    chk({tag, "/key"}, v, exp_open ? 32'h59 : 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
    pats[2] = 32'h1234_5678; pats[3] = 32'h0000_0000;
    exp_base = 32'h00C0_0000; exp_open = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R7 reset");
    rd(2'd2, v); chk("R8 idx2", v, 32'h0);
    rd(2'd3, v); chk("R8 idx3", v, 32'h0);

    // R3 locked sweep and R4/R5/R6 unlocked sweep over every lane pattern
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 4; p++) begin
        wr(2'd1, 4'(b), pats[p] ^ 32'h0F0F_0F0F);
        check_state("R3 locked write");
        wr(2'd0, 4'h1, 32'h0000_0059);
        check_state("R1 unlock");
        wr(2'd1, 4'(b), pats[p]);
        check_state("R4 R5 R6 lane write");
        if (b < 8) begin
          wr(2'd0, 4'h1, 32'h0000_0013);
          check_state("R2 bad key");
        end
      end
    end

    // R2: key write without lane 0 has no effect
    wr(2'd0, 4'hE, 32'h5959_5959);
    check_state("R2 no lane0");
    wr(2'd0, 4'h1, 32'h0000_0059);
    wr(2'd0, 4'hE, 32'h0000_0000);
    check_state("R2 no lane0 while open");

    // R9 correct order
    wr(2'd1, 4'h3, 32'h0000_0000);
    wr(2'd1, 4'hC, 32'h0000_0000);
    wr(2'd0, 4'h1, 32'h0000_0059);
    wr(2'd1, 4'h3, 32'hFFFF_A400);
    wr(2'd1, 4'hC, 32'h0ABC_FFFF);
    check_state("R9 low then high");
    chk("R9 value", base_addr_o, 32'h0ABC_A400);

    // R9 wrong order
    wr(2'd0, 4'h1, 32'h0000_0059);
    wr(2'd1, 4'hC, 32'h0123_0000);
    wr(2'd1, 4'h3, 32'h0000_7C00);
    check_state("R9 high then low");
    chk("R9 low dropped", base_addr_o, 32'h0123_A400);

    // R5 word write commits top byte then relocks
    wr(2'd0, 4'h1, 32'h0000_0059);
    wr(2'd1, 4'hF, 32'hF765_43FF);
    chk("R5 word", base_addr_o, 32'h0765_4000);
    wr(2'd1, 4'hF, 32'h0000_0000);
    check_state("R5 relocked");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule